// File: doc/BRIEF.md
# Four-Channel Prioritized DMA Controller

This block copies data between memory locations on behalf of a processor. It has four independent channels. Software sets each channel's source address, destination address, unit count and control word through a single register write port. A channel starts in one of four ways: at once, on a horizontal-blank pulse, on a vertical-blank pulse, or on its own special-request line. A transfer moves 16-bit or 32-bit units through one memory master port. Each unit is a read followed by a write of the same data.

A single state machine serves the channels in fixed priority, and the lowest index wins. It chooses again after every unit, so a lower channel that becomes pending takes over from a higher one between units. The states are `ST_IDLE`, `ST_READ` and `ST_WRITE`. `ST_IDLE` goes to `ST_READ` when any channel is pending, and the winning channel is latched on that edge. `ST_READ` goes to `ST_WRITE` on the read handshake, and the read data is captured there. `ST_WRITE` returns to `ST_IDLE` on the write handshake, and that channel's addresses and count step forward. A channel can raise a one-cycle interrupt when its transfer completes. A stall output holds the processor off while work is outstanding.

Top module: `dmac_top`

## Requirements
- R1: When several channels are pending, the lowest-numbered one is served. A lower channel that becomes pending while a higher one is running takes over after the current unit's write completes.
- R2: A count write of zero stores the channel's maximum: 0x4000 units for channels 0 to 2 and 0x10000 units for channel 3.
- R3: Address writes are ANDed with 0x0FFFFFFE. A write that fails the range check of R4 is dropped, and the previous value stays in use.
- R4: A source below 0x02000000 is rejected on every channel. Channel 0 also rejects sources from 0x08000000 up to, but not including, 0x0E000000. A destination at or above 0x08000000 is accepted only on channel 3.
- R5: Register select on `reg_sel` is 0 source, 1 destination, 2 count, 3 control. Control bits are: [6:5] destination mode, [8:7] source mode, 9 repeat, 10 width (1 = 32-bit), 12 and 13 start timing, 14 interrupt enable, 15 enable. Bit 11 has no function. When enable rises from 0 to 1, the channel copies its source, destination and count into working registers. It then arms by timing: 0 at once, 1 horizontal blank, 2 vertical blank, 3 special request. Special requests have no effect on channel 0.
- R6: Address modes are 0 increment, 1 decrement, 2 fixed, 3 increment with reload. Each unit steps the address by 2 bytes (16-bit) or 4 bytes (32-bit).
- R7: When enable rises, and when a repeat reloads the destination, the working addresses are aligned down to the unit width. Every 32-bit access address has bits [1:0] equal to zero.
- R8: On the last unit, enable is cleared if repeat is off or the timing is immediate. Otherwise the count reloads from the programmed value and the destination reloads only in mode 3. The source carries on from where it stopped, and the channel waits for its next trigger.
- R9: When interrupt enable is set, the last unit of every transfer pulses that channel's `irq` bit for one cycle, whether or not the channel repeats.
- R10: `cpu_stall` is high while a unit is in progress or any channel is pending, and low otherwise. It is low after reset.
- R11: Each unit is one read request followed by one write request. `m_valid`, `m_write` and `m_addr` hold until `m_ready`. The written data equals the data read.
- R12: A blank pulse arms only enabled channels whose timing matches it. Pulses that arrive while a channel is already pending are absorbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_ch | input | 2 | Channel selected by the write |
| reg_sel | input | 2 | Register selected: 0 source, 1 destination, 2 count, 3 control |
| reg_wdata | input | 32 | Register write data |
| hblank | input | 1 | Horizontal-blank trigger pulse |
| vblank | input | 1 | Vertical-blank trigger pulse |
| special_req | input | 4 | Per-channel special-request pulses |
| m_valid | output | 1 | Memory request valid |
| m_write | output | 1 | 1 for a write request, 0 for a read |
| m_wide | output | 1 | 1 for a 32-bit access, 0 for 16-bit |
| m_addr | output | 32 | Request byte address |
| m_wdata | output | 32 | Write data |
| m_ready | input | 1 | Memory accepts the request; read data is valid |
| m_rdata | input | 32 | Read data |
| irq | output | 4 | Per-channel completion pulses |
| cpu_stall | output | 1 | Processor stall request |

## Verification
The copy path is tested in several ways. There are 16-bit incrementing runs and 32-bit runs with a decrementing source, a fixed destination and a misaligned start, so stepping, direction and alignment can each fail on their own. Triggering is tested by the order in which triggers arrive relative to channel state: blank pulses of the wrong kind, repeated pulses during an active transfer, special requests on channel 0 and on channel 3, and a lower channel requested in the middle of a higher channel's transfer. The last case shows whether priority is taken between units or only between transfers. Repeat runs are fired twice, to show the difference between reloading the destination and continuing the source. Zero-count runs show whether each channel gets its own maximum.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    // control word field positions
    localparam int CB_DMODE = 5;
    localparam int CB_SMODE = 7;
    localparam int CB_RPT   = 9;
    localparam int CB_WIDE  = 10;
    localparam int CB_TIM   = 12;
    localparam int CB_IRQ   = 14;
    localparam int CB_EN    = 15;

    typedef enum logic [1:0] {TM_NOW = 2'd0, TM_HBL = 2'd1, TM_VBL = 2'd2, TM_SPC = 2'd3} timing_e;
    typedef enum logic [1:0] {AM_INC = 2'd0, AM_DEC = 2'd1, AM_FIX = 2'd2, AM_RLD = 2'd3} amode_e;
    typedef enum logic [1:0] {RS_SRC = 2'd0, RS_DST = 2'd1, RS_CNT = 2'd2, RS_CTL = 2'd3} rsel_e;
    typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_READ = 2'd1, ST_WRITE = 2'd2} state_e;

    function automatic logic [31:0] align_addr(input logic [31:0] a, input logic wide);
        return wide ? {a[31:2], 2'b00} : {a[31:1], 1'b0};
    endfunction

    function automatic logic [31:0] step_of(input amode_e md, input logic wide);
        logic [31:0] s;
        s = wide ? 32'd4 : 32'd2;
        unique case (md)
            AM_DEC:  return -s;
            AM_FIX:  return 32'd0;
            default: return s;
        endcase
    endfunction
endpackage

// File: rtl/dmac_channel.sv
module dmac_channel
    import dmac_pkg::*;
#(
    parameter int          CH        = 0,
    parameter int          NCH       = 4,
    parameter int          CNT_W     = 17,
    parameter logic [31:0] RAM_BASE  = 32'h0200_0000,
    parameter logic [31:0] CART_BASE = 32'h0800_0000,
    parameter logic [31:0] SRAM_BASE = 32'h0E00_0000,
    parameter logic [31:0] MAX_SHORT = 32'h0000_4000,
    parameter logic [31:0] MAX_LONG  = 32'h0001_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    input  logic        hblank,
    input  logic        vblank,
    input  logic        special,
    input  logic        unit_done,
    output logic        pend,
    output logic [31:0] src_now,
    output logic [31:0] dst_now,
    output logic        wide,
    output logic        irq
);
    localparam bit               IS_LAST = (CH == NCH - 1);
    localparam logic [CNT_W-1:0] MAX_CNT = IS_LAST ? CNT_W'(MAX_LONG) : CNT_W'(MAX_SHORT);

    logic [31:0]      src_r, dst_r;
    logic [CNT_W-1:0] cnt_r, wcnt;
    logic             en, irq_en, rpt;
    timing_e          tim;
    amode_e           smode, dmode;

    logic [31:0] addr_in;
    logic        src_ok, dst_ok, fire;

    assign addr_in = wr_data & 32'h0FFF_FFFE;
    assign src_ok  = (addr_in >= RAM_BASE) &&
                     !((CH == 0) && (addr_in >= CART_BASE) && (addr_in < SRAM_BASE));
    assign dst_ok  = IS_LAST || (addr_in < CART_BASE);
    assign fire    = en && !pend &&
                     ((hblank && tim == TM_HBL) || (vblank && tim == TM_VBL) ||
                      (special && tim == TM_SPC && CH != 0));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_r <= '0; dst_r <= '0; cnt_r <= MAX_CNT;
            src_now <= '0; dst_now <= '0; wcnt <= MAX_CNT;
            en <= 1'b0; irq_en <= 1'b0; rpt <= 1'b0; wide <= 1'b0;
            tim <= TM_NOW; smode <= AM_INC; dmode <= AM_INC;
            pend <= 1'b0; irq <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (unit_done) begin
                src_now <= src_now + step_of(smode, wide);
                dst_now <= dst_now + step_of(dmode, wide);
                wcnt    <= wcnt - CNT_W'(1);
                if (wcnt == CNT_W'(1)) begin
                    pend <= 1'b0;
                    irq  <= irq_en;
                    if (!rpt || tim == TM_NOW) begin
                        en <= 1'b0;
                    end else begin
                        wcnt <= cnt_r;
                        if (dmode == AM_RLD) dst_now <= align_addr(dst_r, wide);
                    end
                end
            end
            if (fire) pend <= 1'b1;
            if (wr_en) begin
                unique case (rsel_e'(wr_sel))
                    RS_SRC: if (src_ok) src_r <= addr_in;
                    RS_DST: if (dst_ok) dst_r <= addr_in;
                    RS_CNT: cnt_r <= (wr_data[15:0] == 16'h0) ? MAX_CNT : CNT_W'(wr_data[15:0]);
                    RS_CTL: begin
                        en     <= wr_data[CB_EN];
                        irq_en <= wr_data[CB_IRQ];
                        tim    <= timing_e'(wr_data[CB_TIM +: 2]);
                        wide   <= wr_data[CB_WIDE];
                        rpt    <= wr_data[CB_RPT];
                        smode  <= amode_e'(wr_data[CB_SMODE +: 2]);
                        dmode  <= amode_e'(wr_data[CB_DMODE +: 2]);
                        if (!wr_data[CB_EN]) begin
                            pend <= 1'b0;
                        end else if (!en) begin
                            src_now <= align_addr(src_r, wr_data[CB_WIDE]);
                            dst_now <= align_addr(dst_r, wr_data[CB_WIDE]);
                            wcnt    <= cnt_r;
                            pend    <= (wr_data[CB_TIM +: 2] == TM_NOW);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // a completion pulse only ever follows a finished unit
    assert_irq_after_unit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(unit_done));
    // a channel is never pending while disabled
    assert_pend_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> en);
endmodule

// File: rtl/dmac_arbiter.sv
module dmac_arbiter #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
    assign any = |req;
endmodule

// File: rtl/dmac_top.sv
module dmac_top
    import dmac_pkg::*;
#(
    parameter int NCH = 4,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_wr,
    input  logic [IW-1:0]  reg_ch,
    input  logic [1:0]     reg_sel,
    input  logic [31:0]    reg_wdata,
    input  logic           hblank,
    input  logic           vblank,
    input  logic [NCH-1:0] special_req,
    output logic           m_valid,
    output logic           m_write,
    output logic           m_wide,
    output logic [31:0]    m_addr,
    output logic [31:0]    m_wdata,
    input  logic           m_ready,
    input  logic [31:0]    m_rdata,
    output logic [NCH-1:0] irq,
    output logic           cpu_stall
);
    state_e          state, nxt;
    logic [IW-1:0]   cur, pick;
    logic [31:0]     data;
    logic            any_pend;
    logic [NCH-1:0]  pend_v, wide_v, done_v;
    logic [31:0]     src_v [NCH];
    logic [31:0]     dst_v [NCH];

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign done_v[i] = (state == ST_WRITE) && m_ready && (cur == IW'(i));
        dmac_channel #(.CH(i), .NCH(NCH)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .wr_en(reg_wr && reg_ch == IW'(i)), .wr_sel(reg_sel), .wr_data(reg_wdata),
            .hblank(hblank), .vblank(vblank), .special(special_req[i]),
            .unit_done(done_v[i]), .pend(pend_v[i]),
            .src_now(src_v[i]), .dst_now(dst_v[i]), .wide(wide_v[i]), .irq(irq[i])
        );
    end

    dmac_arbiter #(.N(NCH)) u_arb (.req(pend_v), .any(any_pend), .idx(pick));

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (any_pend) nxt = ST_READ;
            ST_READ:  if (m_ready)  nxt = ST_WRITE;
            ST_WRITE: if (m_ready)  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cur   <= '0;
            data  <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && any_pend) cur <= pick;
            if (state == ST_READ && m_ready)  data <= m_rdata;
        end
    end

    always_comb begin
        m_valid   = (state != ST_IDLE);
        m_write   = (state == ST_WRITE);
        m_wide    = wide_v[cur];
        m_addr    = (state == ST_WRITE) ? dst_v[cur] : src_v[cur];
        m_wdata   = data;
        cpu_stall = (state != ST_IDLE) || any_pend;
    end

    assert_hold_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_write)));
    assert_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_wide) |-> (m_addr[1:0] == 2'b00));
    assert_lowest_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && any_pend) |=>
        (($past(pend_v) & ((NCH'(1) << cur) - NCH'(1))) == '0));
    assert_read_then_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_write) |-> ($past(m_valid && !m_write) || $past(m_valid && m_write)));
endmodule

// File: tb/tb_dmac_top.sv
module tb_dmac_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_ch = '0, reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic        hblank = 1'b0, vblank = 1'b0;
    logic [3:0]  special_req = '0;
    logic        m_valid, m_write, m_wide, m_ready = 1'b0, cpu_stall;
    logic [31:0] m_addr, m_wdata, m_rdata;
    logic [3:0]  irq;

    int checks = 0, fails = 0;
    int lat = 0, wt = 0, nw = 0, nr = 0;
    int irq_cnt [4];
    logic [31:0] wa [64];
    logic [31:0] wd [64];
    logic [31:0] ra [64];

    always #5 clk = ~clk;

    dmac_top dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_ch(reg_ch), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .hblank(hblank), .vblank(vblank), .special_req(special_req),
        .m_valid(m_valid), .m_write(m_write), .m_wide(m_wide), .m_addr(m_addr),
        .m_wdata(m_wdata), .m_ready(m_ready), .m_rdata(m_rdata), .irq(irq), .cpu_stall(cpu_stall)
    );

    function automatic logic [31:0] pat(input logic [31:0] a);
        return a ^ 32'h5A5A_0000;
    endfunction
    assign m_rdata = pat(m_addr);

    // memory model: decides ready for the coming edge and logs the transaction
    always @(negedge clk) begin
        m_ready = 1'b0;
        if (rst_n && m_valid) begin
            if (wt >= lat) begin
                m_ready = 1'b1;
                wt = 0;
                if (m_write) begin
                    if (nw < 64) begin wa[nw] = m_addr; wd[nw] = m_wdata; end
                    nw++;
                end else begin
                    if (nr < 64) ra[nr] = m_addr;
                    nr++;
                end
            end else wt++;
        end
        for (int c = 0; c < 4; c++) if (rst_n && irq[c]) irq_cnt[c]++;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        summary();
    end

    function automatic logic [31:0] ctl(input bit en, input bit ie, input logic [1:0] tim,
                                        input bit w, input bit rp, input logic [1:0] sm, input logic [1:0] dm);
        return {16'h0, en, ie, tim, 1'b0, w, rp, sm, dm, 5'b0};
    endfunction

    task automatic wr(input int ch, input int sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_ch = 2'(ch); reg_sel = 2'(sel); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic prog(input int ch, input logic [31:0] s, input logic [31:0] d, input logic [31:0] n);
        wr(ch, 0, s); wr(ch, 1, d); wr(ch, 2, n);
    endtask

    task automatic clear_log();
        nw = 0; nr = 0;
        for (int c = 0; c < 4; c++) irq_cnt[c] = 0;
    endtask

    task automatic wait_idle();
        repeat (2) @(negedge clk);
        while (cpu_stall) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) hblank = 1'b1; else if (which == 1) vblank = 1'b1;
        else special_req[which - 2] = 1'b1;
        @(negedge clk);
        hblank = 1'b0; vblank = 1'b0; special_req = '0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!cpu_stall, "R10 stall low after reset", 32'(cpu_stall), 32'd0);
        chk(!m_valid && irq == 4'h0, "R11 port idle after reset", {m_valid, irq}, 32'd0);
    endtask

    task automatic t_basic();
        clear_log(); lat = 1;
        prog(0, 32'h0200_0100, 32'h0300_0200, 3);
        wr(0, 3, ctl(1, 1, 0, 0, 0, 0, 0));
        @(negedge clk);
        chk(cpu_stall, "R10 stall while pending", 32'(cpu_stall), 32'd1);
        wait_idle();
        chk(nw == 3, "R5 immediate unit count", nw, 3);
        for (int i = 0; i < 3; i++) begin
            chk(wa[i] == 32'h0300_0200 + 2 * i, "R6 increment dest", wa[i], 32'h0300_0200 + 2 * i);
            chk(wd[i] == pat(32'h0200_0100 + 2 * i), "R11 data copied", wd[i], pat(32'h0200_0100 + 2 * i));
        end
        chk(irq_cnt[0] == 1, "R9 one irq pulse", irq_cnt[0], 1);
        chk(!cpu_stall, "R10 stall released", 32'(cpu_stall), 0);
    endtask

    task automatic t_modes();
        clear_log(); lat = 0;
        prog(1, 32'h0200_0402, 32'h0300_0012, 3);
        wr(1, 3, ctl(1, 0, 0, 1, 0, 1, 2));
        wait_idle();
        chk(nr == 3 && nw == 3, "R6 unit count", nw, 3);
        chk(ra[0] == 32'h0200_0400, "R7 source aligned", ra[0], 32'h0200_0400);
        chk(ra[2] == 32'h0200_03F8, "R6 decrement by 4", ra[2], 32'h0200_03F8);
        chk(wa[0] == 32'h0300_0010 && wa[2] == 32'h0300_0010, "R6 fixed dest", wa[2], 32'h0300_0010);
    endtask

    task automatic t_imm_no_repeat();
        clear_log(); lat = 0;
        prog(2, 32'h0200_0800, 32'h0300_0800, 2);
        wr(2, 3, ctl(1, 0, 0, 0, 1, 0, 0));
        wait_idle();
        repeat (20) @(negedge clk);
        chk(nw == 2, "R8 immediate repeat runs once", nw, 2);
        wr(2, 3, ctl(1, 0, 0, 0, 1, 0, 0));
        wait_idle();
        chk(nw == 4 && ra[2] == 32'h0200_0800, "R8 enable cleared, restart copies", ra[2], 32'h0200_0800);
    endtask

    task automatic t_repeat_hblank();
        clear_log(); lat = 0;
        prog(1, 32'h0200_0C00, 32'h0300_0C00, 2);
        wr(1, 3, ctl(1, 1, 1, 0, 1, 0, 3));
        repeat (10) @(negedge clk);
        chk(nw == 0 && !cpu_stall, "R5 hblank channel waits", nw, 0);
        pulse(1);
        repeat (10) @(negedge clk);
        chk(nw == 0, "R12 vblank ignored by hblank channel", nw, 0);
        pulse(0);
        wait_idle();
        chk(nw == 2 && wa[1] == 32'h0300_0C02, "R5 hblank run", wa[1], 32'h0300_0C02);
        chk(irq_cnt[1] == 1, "R9 irq first pass", irq_cnt[1], 1);
        pulse(0);
        wait_idle();
        chk(nw == 4 && wa[2] == 32'h0300_0C00, "R8 dest reloaded", wa[2], 32'h0300_0C00);
        chk(ra[2] == 32'h0200_0C04, "R8 source continues", ra[2], 32'h0200_0C04);
        chk(irq_cnt[1] == 2, "R9 irq on repeat", irq_cnt[1], 2);
        wr(1, 3, 32'h0);
    endtask

    task automatic t_absorb();
        clear_log(); lat = 4;
        prog(2, 32'h0200_1000, 32'h0300_1000, 2);
        wr(2, 3, ctl(1, 0, 2, 0, 1, 0, 0));
        pulse(1);
        repeat (2) @(negedge clk);
        pulse(1);
        wait_idle();
        chk(nw == 2, "R12 second pulse absorbed", nw, 2);
        wr(2, 3, 32'h0);
    endtask

    task automatic t_special();
        clear_log(); lat = 0;
        prog(0, 32'h0200_1400, 32'h0300_1400, 1);
        wr(0, 3, ctl(1, 0, 3, 0, 0, 0, 0));
        pulse(2);
        repeat (10) @(negedge clk);
        chk(nw == 0 && !cpu_stall, "R5 special ignored on channel 0", nw, 0);
        wr(0, 3, 32'h0);
        prog(3, 32'h0200_1500, 32'h0300_1500, 1);
        wr(3, 3, ctl(1, 0, 3, 0, 0, 0, 0));
        pulse(5);
        wait_idle();
        chk(nw == 1 && wa[0] == 32'h0300_1500, "R5 special on channel 3", wa[0], 32'h0300_1500);
    endtask

    task automatic t_addr_check();
        clear_log(); lat = 0;
        prog(0, 32'h0200_0000, 32'h0300_2000, 1);
        wr(0, 0, 32'h0800_0000);
        wr(0, 3, ctl(1, 0, 0, 0, 0, 0, 0));
        wait_idle();
        chk(ra[0] == 32'h0200_0000, "R4 channel 0 cart source rejected", ra[0], 32'h0200_0000);
        wr(0, 0, 32'h0100_0000);
        wr(0, 0, 32'hF200_0041);
        wr(0, 3, ctl(1, 0, 0, 0, 0, 0, 0));
        wait_idle();
        chk(ra[1] == 32'h0200_0040, "R3 mask and low source rejected", ra[1], 32'h0200_0040);
        prog(1, 32'h0800_0000, 32'h0300_3000, 1);
        wr(1, 1, 32'h0800_0000);
        wr(1, 3, ctl(1, 0, 0, 0, 0, 0, 0));
        wait_idle();
        chk(ra[2] == 32'h0800_0000, "R4 channel 1 cart source accepted", ra[2], 32'h0800_0000);
        chk(wa[2] == 32'h0300_3000, "R4 channel 1 cart dest rejected", wa[2], 32'h0300_3000);
        prog(3, 32'h0200_0000, 32'h0800_0010, 1);
        wr(3, 3, ctl(1, 0, 0, 0, 0, 0, 0));
        wait_idle();
        chk(wa[3] == 32'h0800_0010, "R4 channel 3 cart dest accepted", wa[3], 32'h0800_0010);
    endtask

    task automatic t_priority();
        clear_log(); lat = 3;
        prog(1, 32'h0200_4000, 32'h0310_0000, 2);
        wr(1, 3, ctl(1, 0, 3, 0, 0, 0, 0));
        prog(2, 32'h0200_5000, 32'h0320_0000, 4);
        wr(2, 3, ctl(1, 0, 0, 0, 0, 0, 0));
        wait (nw >= 1);
        special_req[1] = 1'b1;
        @(negedge clk);
        special_req = '0;
        wait_idle();
        chk(nw == 6, "R1 total units", nw, 6);
        chk(wa[0][23:20] == 4'h2, "R1 first unit channel 2", 32'(wa[0][23:20]), 2);
        chk(wa[1][23:20] == 4'h1 && wa[2][23:20] == 4'h1, "R1 channel 1 preempts", 32'(wa[1][23:20]), 1);
        chk(wa[3] == 32'h0320_0002, "R1 channel 2 resumes", wa[3], 32'h0320_0002);
    endtask

    task automatic t_zero_count();
        clear_log(); lat = 0;
        prog(0, 32'h0200_0000, 32'h0300_0000, 0);
        wr(0, 3, ctl(1, 1, 0, 0, 0, 0, 0));
        wait_idle();
        chk(nw == 32'h4000, "R2 channel 0 zero count", nw, 32'h4000);
        chk(irq_cnt[0] == 1, "R9 irq after max run", irq_cnt[0], 1);
        clear_log();
        prog(3, 32'h0200_0000, 32'h0300_0000, 0);
        wr(3, 3, ctl(1, 1, 0, 0, 0, 0, 0));
        wait (nw >= 32'h4002);
        chk(irq_cnt[3] == 0 && cpu_stall, "R2 channel 3 runs past 0x4000", irq_cnt[3], 0);
        wr(3, 3, 32'h0);
        wait_idle();
        chk(!cpu_stall && irq_cnt[3] == 0, "R10 stall released on disable", 32'(cpu_stall), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_modes();
        t_imm_no_repeat();
        t_repeat_hblank();
        t_absorb();
        t_special();
        t_addr_check();
        t_priority();
        t_zero_count();
        summary();
    end
endmodule